// File: doc/BRIEF.md
# Multi-Source Interrupt Request Combiner

This block gathers interrupt requests from five peripheral sources on a CPU bus and merges them onto one shared active-low request line. The line behaves like a wired-OR: it idles high and is pulled low while any source holds a request. Each source has its own enable bit and its own pending flag. A one-cycle pulse on the source's event input sets the flag, and only while that source is enabled.

Software controls each source through bus writes to fixed addresses, and each source has its own encoding for turning on and off. Software acknowledges a request in one of three ways, depending on the source. It can read a status address, it can disable and then re-enable the source, or it can start a new operation, which for the sample source is signalled by a dedicated restart pulse. Reads of the acknowledge addresses return the pending state in bit 7. The peripherals that raise the events are outside this block.

The bus is a plain single-cycle strobe interface and has no back-pressure. A write or read is taken in the cycle its strobe is high, and read data is valid combinationally in that same cycle. Write and read strobes are never high together.

Top module: `irq_hub`

## Requirements
- R1: After reset every source is disabled and not pending, `irq_n` is 1, and every read returns 0.
- R2: `irq_n` is 0 exactly while at least one source is pending, and a source can only be pending while it is enabled.
- R3: Sample source: a write to 0x4010 with data bit 7 = 1 enables it, and any other write to 0x4010 disables it. A `smp_restart` pulse clears its pending flag at the next clock edge.
- R4: Frame source: a write to 0x4017 with data bits 7:6 = 00 enables it, and any other value disables it. A read of 0x4015 clears its pending flag.
- R5: Scanline source: any write to 0xE001 enables it, and any write to 0xE000 disables it, whatever the data.
- R6: Mapper source: writing 0x80 to 0x5204 enables it and writing 0x00 disables it. Any other value written there has no effect. A read of 0x5204 clears its pending flag.
- R7: Disk source: writing 0x02 to 0x4022 enables it and writing 0x00 disables it. Any other value has no effect. A read of 0x4030 clears its pending flag.
- R8: Disabling a source clears its pending flag. An event that arrives while the source is disabled is dropped. A repeated enable write to a source that is already enabled leaves its pending flag unchanged.
- R9: A read of 0x4015, 0x5204 or 0x4030 returns that source's pending state from before the clear in bit 7, with all other bits 0, during the read cycle. The flag clears at the end of that cycle. A read of any other address returns 0.
- R10: An event that coincides with a clear (a read acknowledge or a restart) wins, and the flag stays set. An event that coincides with a disable write is dropped.
- R11: The bits of `evt` map to sources as follows: bit 0 sample, bit 1 frame, bit 2 scanline, bit 3 mapper, bit 4 disk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | CPU bus address |
| bus_wdata | input | 8 | CPU write data |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_rd | input | 1 | Read strobe, one access per high cycle |
| bus_rdata | output | 8 | Read data, valid in the read cycle |
| evt | input | 5 | Per-source event pulses (mapping in R11) |
| smp_restart | input | 1 | Sample-source new-operation pulse, acts as its acknowledge |
| irq_n | output | 1 | Combined active-low interrupt request |

## Verification
Two functions can fall in the same cycle: setting a flag through an event, and clearing it through an acknowledge read, a restart pulse or a disable write. The bench drives an event pulse in the very cycle of a 0x4015 read, and in the very cycle of a 0x4022 disable write. It judges the read data in that cycle, and `irq_n` one cycle later, against the priority in R10. Coincident restart and event on the sample source is judged in the same way.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int NSRC   = 5;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  localparam int S_SMP = 0;
  localparam int S_FRM = 1;
  localparam int S_LIN = 2;
  localparam int S_MAP = 3;
  localparam int S_DSK = 4;

  localparam logic [ADDR_W-1:0] A_SMP_CTL = 16'h4010;
  localparam logic [ADDR_W-1:0] A_FRM_CTL = 16'h4017;
  localparam logic [ADDR_W-1:0] A_FRM_ACK = 16'h4015;
  localparam logic [ADDR_W-1:0] A_LIN_OFF = 16'hE000;
  localparam logic [ADDR_W-1:0] A_LIN_ON  = 16'hE001;
  localparam logic [ADDR_W-1:0] A_MAP_REG = 16'h5204;
  localparam logic [ADDR_W-1:0] A_DSK_CTL = 16'h4022;
  localparam logic [ADDR_W-1:0] A_DSK_ACK = 16'h4030;

  localparam logic [DATA_W-1:0] V_MAP_ON  = 8'h80;
  localparam logic [DATA_W-1:0] V_MAP_OFF = 8'h00;
  localparam logic [DATA_W-1:0] V_DSK_ON  = 8'h02;
  localparam logic [DATA_W-1:0] V_DSK_OFF = 8'h00;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_hub_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr,
  input  logic              rd,
  input  logic              restart,
  output logic [NSRC-1:0]   turn_on,
  output logic [NSRC-1:0]   turn_off,
  output logic [NSRC-1:0]   clr,
  output logic [NSRC-1:0]   rd_hit
);
  logic wr_smp, wr_frm, wr_map, wr_dsk;
  logic rd_frm, rd_map, rd_dsk;

  always_comb begin
    wr_smp = wr && (addr == A_SMP_CTL);
    wr_frm = wr && (addr == A_FRM_CTL);
    wr_map = wr && (addr == A_MAP_REG);
    wr_dsk = wr && (addr == A_DSK_CTL);
    rd_frm = rd && (addr == A_FRM_ACK);
    rd_map = rd && (addr == A_MAP_REG);
    rd_dsk = rd && (addr == A_DSK_ACK);

    turn_on  = '0;
    turn_off = '0;
    clr      = '0;
    rd_hit   = '0;

    turn_on[S_SMP]  = wr_smp &&  wdata[DATA_W-1];
    turn_off[S_SMP] = wr_smp && !wdata[DATA_W-1];
    clr[S_SMP]      = restart;

    turn_on[S_FRM]  = wr_frm && (wdata[DATA_W-1 -: 2] == 2'b00);
    turn_off[S_FRM] = wr_frm && (wdata[DATA_W-1 -: 2] != 2'b00);
    clr[S_FRM]      = rd_frm;
    rd_hit[S_FRM]   = rd_frm;

    turn_on[S_LIN]  = wr && (addr == A_LIN_ON);
    turn_off[S_LIN] = wr && (addr == A_LIN_OFF);

    turn_on[S_MAP]  = wr_map && (wdata == V_MAP_ON);
    turn_off[S_MAP] = wr_map && (wdata == V_MAP_OFF);
    clr[S_MAP]      = rd_map;
    rd_hit[S_MAP]   = rd_map;

    turn_on[S_DSK]  = wr_dsk && (wdata == V_DSK_ON);
    turn_off[S_DSK] = wr_dsk && (wdata == V_DSK_OFF);
    clr[S_DSK]      = rd_dsk;
    rd_hit[S_DSK]   = rd_dsk;
  end

  always_comb begin
    AST_RD_HIT_ONEHOT: assert ($onehot0(rd_hit)); // R9
  end
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic turn_on,
  input  logic turn_off,
  input  logic clr,
  input  logic evt,
  output logic en_q,
  output logic pend_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (turn_off)     en_q <= 1'b0;
      else if (turn_on) en_q <= 1'b1;
      pend_q <= en_q && !turn_off && (evt || (pend_q && !clr));
    end
  end

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    turn_off |=> !pend_q); // R8
  AST_DROP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !pend_q); // R8
  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !turn_off && evt) |=> pend_q); // R10
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !pend_q); // R9
  AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> en_q); // R2
endmodule

// File: rtl/irq_readback.sv
module irq_readback
  import irq_hub_pkg::*;
(
  input  logic [NSRC-1:0]   rd_hit,
  input  logic [NSRC-1:0]   pend,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    rdata[DATA_W-1] = |(rd_hit & pend);
  end

  always_comb begin
    AST_RD_LOW_BITS_ZERO: assert (rdata[DATA_W-2:0] == '0); // R9
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   evt,
  input  logic              smp_restart,
  output logic              irq_n
);
  logic [NSRC-1:0] turn_on, turn_off, clr, rd_hit;
  logic [NSRC-1:0] en, pend;

  irq_bus_decode u_dec (
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .restart  (smp_restart),
    .turn_on  (turn_on),
    .turn_off (turn_off),
    .clr      (clr),
    .rd_hit   (rd_hit)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    irq_src_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .turn_on  (turn_on[i]),
      .turn_off (turn_off[i]),
      .clr      (clr[i]),
      .evt      (evt[i]),
      .en_q     (en[i]),
      .pend_q   (pend[i])
    );
  end

  irq_readback u_rb (
    .rd_hit (rd_hit),
    .pend   (pend),
    .rdata  (bus_rdata)
  );

  assign irq_n = ~(|pend);

  AST_IRQ_DROPS_ON_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & en & ~turn_off)) |=> !irq_n); // R2
  AST_NO_RD_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0)); // R9
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd)); // R9
endmodule

// File: tb/irq_hub_test.sv
module irq_hub_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [4:0]  evt = '0;
  logic        smp_restart = 1'b0;
  logic        irq_n;

  int checks = 0;
  int fails  = 0;
  logic [7:0] last_rd;

  always #4 clk = ~clk;

  irq_hub uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .evt(evt),
    .smp_restart(smp_restart), .irq_n(irq_n)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one bus cycle, optionally with events; returns at the next negedge
  task automatic cyc(logic w, logic r, logic [15:0] a, logic [7:0] d,
                     logic [4:0] e, logic rs);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    evt = e; smp_restart = rs;
    #2 last_rd = bus_rdata;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    evt = '0; smp_restart = 0;
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d); cyc(1, 0, a, d, '0, 0); endtask
  task automatic rd(logic [15:0] a);                cyc(0, 1, a, '0, '0, 0); endtask
  task automatic ev(logic [4:0] e);                 cyc(0, 0, '0, '0, e, 0); endtask

  task automatic t_reset();
    chk("R1 irq_n after reset", {7'b0, irq_n}, 8'h01);
    rd(16'h4015); chk("R1 read 4015 after reset", last_rd, 8'h00);
    ev(5'h1F);    chk("R1 events while all disabled", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_sample();
    ev(5'b00001); chk("R8 sample evt while disabled dropped", {7'b0, irq_n}, 8'h01);
    wr(16'h4010, 8'h8F); ev(5'b00001);
    chk("R3 R11 sample enabled evt bit0", {7'b0, irq_n}, 8'h00);
    cyc(0, 0, '0, '0, '0, 1);
    chk("R3 restart clears", {7'b0, irq_n}, 8'h01);
    ev(5'b00001); cyc(0, 0, '0, '0, 5'b00001, 1);
    chk("R10 restart with evt keeps pending", {7'b0, irq_n}, 8'h00);
    wr(16'h4010, 8'h7F);
    chk("R8 R3 bit7=0 write disables and clears", {7'b0, irq_n}, 8'h01);
    wr(16'h4010, 8'h80);
    chk("R8 re-enable does not restore", {7'b0, irq_n}, 8'h01);
    wr(16'h4010, 8'h00);
  endtask

  task automatic t_frame();
    wr(16'h4017, 8'h40); ev(5'b00010);
    chk("R4 bits 7:6=01 disables", {7'b0, irq_n}, 8'h01);
    wr(16'h4017, 8'h3F); ev(5'b00010);
    chk("R4 R11 bits 7:6=00 enables, evt bit1", {7'b0, irq_n}, 8'h00);
    rd(16'h4010); chk("R9 other address reads 0", last_rd, 8'h00);
    chk("R9 other read leaves pending", {7'b0, irq_n}, 8'h00);
    rd(16'h4015); chk("R9 R4 ack read returns 0x80", last_rd, 8'h80);
    chk("R4 read 4015 clears", {7'b0, irq_n}, 8'h01);
    rd(16'h4015); chk("R9 second read returns 0", last_rd, 8'h00);
  endtask

  task automatic t_overlap();
    ev(5'b00010);
    cyc(0, 1, 16'h4015, '0, 5'b00010, 0);
    chk("R10 read with evt returns pre-clear", last_rd, 8'h80);
    chk("R10 evt wins over read clear", {7'b0, irq_n}, 8'h00);
    rd(16'h4015);
    chk("R10 later read clears", {7'b0, irq_n}, 8'h01);
    wr(16'h4017, 8'hC0);
    wr(16'h4022, 8'h02);
    cyc(1, 0, 16'h4022, 8'h00, 5'b10000, 0);
    chk("R10 disable with evt drops evt", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_scanline();
    wr(16'hE001, 8'h00); ev(5'b00100);
    chk("R5 R11 any E001 write enables", {7'b0, irq_n}, 8'h00);
    wr(16'hE001, 8'h55);
    chk("R8 repeated enable keeps pending", {7'b0, irq_n}, 8'h00);
    wr(16'hE000, 8'hFF);
    chk("R5 E000 write disables and clears", {7'b0, irq_n}, 8'h01);
    wr(16'hE001, 8'h00);
    chk("R5 re-enable stays clear", {7'b0, irq_n}, 8'h01);
    wr(16'hE000, 8'h00);
  endtask

  task automatic t_mapper();
    wr(16'h5204, 8'h40); ev(5'b01000);
    chk("R6 value 0x40 does not enable", {7'b0, irq_n}, 8'h01);
    wr(16'h5204, 8'h80); ev(5'b01000);
    chk("R6 R11 0x80 enables, evt bit3", {7'b0, irq_n}, 8'h00);
    wr(16'h5204, 8'h01);
    chk("R6 value 0x01 ignored", {7'b0, irq_n}, 8'h00);
    rd(16'h5204); chk("R6 R9 read returns 0x80", last_rd, 8'h80);
    chk("R6 read clears", {7'b0, irq_n}, 8'h01);
    wr(16'h5204, 8'h00); ev(5'b01000);
    chk("R6 0x00 disables", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_disk();
    wr(16'h4022, 8'h03); ev(5'b10000);
    chk("R7 value 0x03 does not enable", {7'b0, irq_n}, 8'h01);
    wr(16'h4022, 8'h02); ev(5'b10000);
    chk("R7 R11 0x02 enables, evt bit4", {7'b0, irq_n}, 8'h00);
    rd(16'h4022); chk("R9 ctl address read returns 0", last_rd, 8'h00);
    rd(16'h4030); chk("R7 R9 read 4030 returns 0x80", last_rd, 8'h80);
    chk("R7 read clears", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_multi();
    wr(16'h4017, 8'h00); wr(16'h5204, 8'h80);
    ev(5'b01010);
    rd(16'h4015); chk("R2 one of two cleared keeps irq low", {7'b0, irq_n}, 8'h00);
    rd(16'h5204); chk("R2 all cleared releases irq", {7'b0, irq_n}, 8'h01);
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sample();
    t_frame();
    t_overlap();
    t_scanline();
    t_mapper();
    t_disk();
    t_multi();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule